// File: doc/BRIEF.md
# Converter Clock Prescaler and Result Formatter

This block is the digital control slice of a successive-approximation converter. It builds a one-cycle converter clock enable. The enable comes from one of two time bases: every cycle of the bus clock, or the cycles in which an oscillator tick strobe is high. That source is divided by a programmable power of two. Software should choose the source and ratio so that the enabled rate is close to 1 MHz, because a rate that is too slow gives wrong conversion results.

When the converter reports a finished conversion, the block places the raw 10-bit result into a high and a low 8-bit data register. Four layouts are available: 8-bit truncated, right justified, left justified, and left justified signed.

The block runs on the bus clock. The oscillator is seen as a tick strobe that is already synchronous to that clock. All configuration fields are loaded together by a single write strobe.

Top module: `adc_prescale_fmt`

## Requirements
- R1: After reset, the enable and both data registers are 0, the source is the oscillator tick, the divide code is 000 and the layout is right justified.
- R2: The divide code sets how many source ticks make one enable pulse: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8.
- R3: Any divide code with bit 2 set gives one enable pulse per 16 source ticks, whatever bits 1:0 hold.
- R4: Source select 1 counts every bus clock cycle. Source select 0 counts only the cycles in which `osc_tick` is 1.
- R5: The enable is high for exactly one cycle. It rises in the cycle after the source tick that completes a count.
- R6: A configuration write clears the tick count, and the enable is 0 in the cycle after the write.
- R7: Layout 00 (truncated): `data_lo` = result[9:2] and `data_hi` = 0.
- R8: Layout 01 (right justified): `data_hi` = {6'b0, result[9:8]} and `data_lo` = result[7:0].
- R9: Layout 10 (left justified): `data_hi` = result[9:2] and `data_lo` = {result[1:0], 6'b0}.
- R10: Layout 11 (signed): like layout 10, except that `data_hi[7]` holds the inverse of result[9].
- R11: The data registers change only in the cycle after `conv_done`. A layout write takes effect from the next conversion, and a write in the same cycle as `conv_done` does not affect that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator tick strobe, synchronous to clk |
| cfg_we | input | 1 | Loads all configuration fields together |
| cfg_div | input | 3 | Divide code |
| cfg_src | input | 1 | Source select: 1 bus clock, 0 oscillator tick |
| cfg_mode | input | 2 | Result layout code |
| conv_done | input | 1 | Conversion complete strobe |
| raw_result | input | 10 | Raw conversion result |
| adc_clk_en | output | 1 | One-cycle converter clock enable |
| data_hi | output | 8 | High data register |
| data_lo | output | 8 | Low data register |

## Verification
A wrong tick count or a stale divide code shows up on `adc_clk_en` within one divide period: a pulse comes early or late, or a pulse is missing. Because the reference model is compared on every clock, the error is reported in the first cycle that differs. A wrong layout code shows up in the data registers one cycle after the next `conv_done`. A result that lands outside `conv_done` shows up as data registers that change while they should hold.

// File: rtl/adc_prescale_fmt.sv
module adc_prescale_fmt #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_src,
  input  logic [1:0]       cfg_mode,
  input  logic             conv_done,
  input  logic [9:0]       raw_result,
  output logic             adc_clk_en,
  output logic [7:0]       data_hi,
  output logic [7:0]       data_lo
);
  localparam int CNT_W = 2 ** (DIV_W - 1);

  logic [DIV_W-1:0] div_q;
  logic             src_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             tick;
  logic [7:0]       fmt_hi, fmt_lo;

  assign tick = src_q | osc_tick;
  assign lim  = div_q[DIV_W-1] ? '1
              : (CNT_W'(1) << div_q[DIV_W-2:0]) - CNT_W'(1);

  always_comb begin
    case (mode_q)
      2'b00:   begin fmt_hi = 8'h00;                             fmt_lo = raw_result[9:2]; end
      2'b01:   begin fmt_hi = {6'b0, raw_result[9:8]};           fmt_lo = raw_result[7:0]; end
      2'b10:   begin fmt_hi = raw_result[9:2];                   fmt_lo = {raw_result[1:0], 6'b0}; end
      default: begin fmt_hi = {~raw_result[9], raw_result[8:2]}; fmt_lo = {raw_result[1:0], 6'b0}; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q      <= '0;
      src_q      <= 1'b0;
      mode_q     <= 2'b01;
      cnt_q      <= '0;
      adc_clk_en <= 1'b0;
      data_hi    <= 8'h00;
      data_lo    <= 8'h00;
    end else begin
      adc_clk_en <= 1'b0;
      if (cfg_we) begin
        div_q  <= cfg_div;
        src_q  <= cfg_src;
        mode_q <= cfg_mode;
        cnt_q  <= '0;
      end else if (tick) begin
        if (cnt_q == lim) begin
          cnt_q      <= '0;
          adc_clk_en <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      if (conv_done) begin
        data_hi <= fmt_hi;
        data_lo <= fmt_lo;
      end
    end
  end
endmodule

module adc_prescale_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_tick,
  input logic       cfg_we,
  input logic       conv_done,
  input logic [9:0] raw_result,
  input logic       src_q,
  input logic [2:0] div_q,
  input logic [1:0] mode_q,
  input logic       adc_clk_en,
  input logic [7:0] data_hi,
  input logic [7:0] data_lo
);
  AST_HOLD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable({data_hi, data_lo}));                               // R11
  AST_TRUNC_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && mode_q == 2'b00 |=> data_hi == 8'h00);                       // R7
  AST_RIGHT_HI_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && mode_q == 2'b01 |=> data_hi[7:2] == 6'b0);                   // R8
  AST_LEFT_LO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && mode_q[1] |=> data_lo[5:0] == 6'b0);                         // R9
  AST_SIGN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && mode_q == 2'b11 |=> data_hi[7] == !$past(raw_result[9]));    // R10
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !adc_clk_en);                                                  // R6
  AST_OSC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !src_q && !osc_tick |=> !adc_clk_en);                                     // R4
  AST_DIV1_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    src_q && div_q == 3'b000 && !cfg_we |=> adc_clk_en);                      // R2
endmodule

bind adc_prescale_fmt adc_prescale_fmt_chk chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cfg_we(cfg_we),
  .conv_done(conv_done), .raw_result(raw_result), .src_q(src_q),
  .div_q(div_q), .mode_q(mode_q), .adc_clk_en(adc_clk_en),
  .data_hi(data_hi), .data_lo(data_lo)
);

// File: tb/tb_adc_prescale_fmt.sv
module tb_adc_prescale_fmt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_div = '0;
  logic       cfg_src = 1'b0;
  logic [1:0] cfg_mode = 2'b01;
  logic       conv_done = 1'b0;
  logic [9:0] raw_result = '0;
  logic       adc_clk_en;
  logic [7:0] data_hi, data_lo;

  int    vectors = 0, fails = 0, cycles = 0;
  string tag = "R1";
  bit    done_flag = 0;

  integer m_cnt = 0, m_div = 0, m_src = 0, m_mode = 1, m_ratio;
  bit     m_en = 0;
  integer m_hi = 0, m_lo = 0, r;

  always #4 clk = ~clk;

  adc_prescale_fmt dut (.*);

  // Behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_div = 0; m_src = 0; m_mode = 1; m_hi = 0; m_lo = 0;
    end else begin
      m_ratio = (m_div >= 4) ? 16 : (1 << m_div);
      if (conv_done) begin
        r = raw_result;
        case (m_mode)
          0: begin m_hi = 0;              m_lo = r / 4; end
          1: begin m_hi = r / 256;        m_lo = r % 256; end
          2: begin m_hi = r / 4;          m_lo = (r % 4) * 64; end
          default: begin m_hi = (r / 4) ^ 128; m_lo = (r % 4) * 64; end
        endcase
      end
      m_en = 0;
      if (cfg_we) begin
        m_cnt = 0; m_div = cfg_div; m_src = cfg_src; m_mode = cfg_mode;
      end else if (m_src == 1 || osc_tick) begin
        m_cnt++;
        if (m_cnt == m_ratio) begin m_cnt = 0; m_en = 1; end
      end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (adc_clk_en !== m_en) begin
      fails++;
      $display("FAIL %s/R5 adc_clk_en=%b expected %b at cycle %0d", tag, adc_clk_en, m_en, cycles);
    end
    if (data_hi !== 8'(m_hi) || data_lo !== 8'(m_lo)) begin
      fails++;
      $display("FAIL %s/R11 data=%h_%h expected %h_%h at cycle %0d",
               tag, data_hi, data_lo, 8'(m_hi), 8'(m_lo), cycles);
    end
  end

  task automatic run(input int n, input int osc_mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      osc_tick = (osc_mode == 0) ? ((i % 3) == 0) : 1'($urandom_range(0, 1));
    end
  endtask

  task automatic wr(input int d, input int s, input int m);
    @(negedge clk);
    cfg_we = 1; cfg_div = 3'(d); cfg_src = 1'(s); cfg_mode = 2'(m);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic conv(input logic [9:0] v);
    @(negedge clk);
    conv_done = 1; raw_result = v;
    @(negedge clk);
    conv_done = 0; raw_result = 10'($urandom);
  endtask

  initial begin
    tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1;
    run(40, 0);                              // R1: default source osc, ratio 1
    conv(10'h2A5);                           // R1: default right-justified
    tag = "R2";
    for (int d = 0; d < 4; d++) begin wr(d, 1, 1); run(40, 0); end
    tag = "R3";
    for (int d = 4; d < 8; d++) begin wr(d, 1, 1); run(50, 0); end
    tag = "R4";
    wr(1, 0, 1); run(60, 1);
    wr(2, 0, 1); run(60, 0);
    wr(7, 0, 1); run(120, 1);
    tag = "R6";
    wr(3, 1, 1); run(5, 0); wr(3, 1, 1); run(3, 0); wr(2, 1, 1); run(20, 0);
    tag = "R7";  wr(0, 1, 0); conv(10'h3FF); conv(10'h155); run(3, 0);
    tag = "R8";  wr(0, 1, 1); conv(10'h3FF); conv(10'h2C3); run(3, 0);
    tag = "R9";  wr(0, 1, 2); conv(10'h1FF); conv(10'h203); run(3, 0);
    tag = "R10"; wr(0, 1, 3); conv(10'h200); conv(10'h1FF); conv(10'h000); run(3, 0);
    tag = "R11";
    wr(0, 1, 0); run(10, 0);                 // layout change alone leaves data as is
    @(negedge clk);
    cfg_we = 1; cfg_mode = 2'b10; conv_done = 1; raw_result = 10'h37B;
    @(negedge clk);
    cfg_we = 0; conv_done = 0;
    run(4, 0); conv(10'h37B);
    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 0) wr($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 3));
      conv(10'($urandom)); run(2, 1);
    end
    done_flag = 1;
  end

  initial begin
    wait (done_flag || cycles > 100000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired in %s", tag);
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule